// File: doc/BRIEF.md
# Predicated Packed-Integer Vector ALU

This unit executes one integer vector operation per cycle on a wide operand pair. The operand pair carries no type of its own. A runtime element-size field splits it into lanes of 8, 16, 32 or 64 bits, and every lane runs the same operation in the same cycle. Three operations are supported:

- a lane-wise wrapping add;
- a lane-wise signed greater-than compare, which yields one mask bit per lane;
- a predicated add, whose per-lane enables come from a small bank of mask registers.

A compare writes its lane mask into a chosen mask register. A later predicated add names that register as its predicate source. Lanes that are not enabled either keep the corresponding lane of the supplied old destination or are forced to zero. Mask register index 0 is hardwired to mean "every lane enabled". Results leave through one register stage, and a valid bit qualifies them.

Top module: `vec_lane_alu`

## Requirements
- R1: The element-size field selects the lane width: 2'b00 = 8-bit, 2'b01 = 16-bit, 2'b10 = 32-bit, 2'b11 = 64-bit. The lane count equals VW divided by the lane width. Lane k occupies bits [k*w +: w] and is governed by mask bit k.
- R2: Opcode 2'b00 adds each lane of A to the same lane of B modulo 2^w. No carry crosses a lane boundary.
- R3: Opcode 2'b01 sets result-mask bit k when lane k of A is greater than lane k of B as signed numbers. Mask bits at or above the lane count are zero.
- R4: A compare also stores its result mask into mask register `mask_wr_idx`, and that value takes effect for an instruction issued in the very next cycle. A store aimed at index 0 is discarded.
- R5: Opcode 2'b10 (predicated add) yields A+B in every lane whose predicate bit is 1. With `zero_off` = 0, a lane whose predicate bit is 0 yields the same lane of `old_dst`. When `old_dst` equals A, this gives A+B where the predicate is set and A elsewhere.
- R6: With `zero_off` = 1, a predicated add writes all-zero bits into every lane whose predicate bit is 0.
- R7: Predicate index 0 enables every lane, whatever has been stored toward index 0.
- R8: `res_valid` goes high exactly one cycle after `in_valid`. While `in_valid` is low, `res_vec` and `res_mask` hold their last values.
- R9: A synchronous reset clears every mask register, `res_valid`, `res_vec` and `res_mask`. After reset, a predicated add through any index other than 0 treats all lanes as disabled.
- R10: `res_mask` is zero for every opcode other than the compare. `res_vec` is zero for a compare and for the reserved opcode 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction present this cycle |
| opcode | input | 2 | 00 add, 01 signed compare, 10 predicated add, 11 reserved |
| elem_size | input | 2 | Lane width select (see R1) |
| src_a | input | VW | First vector operand |
| src_b | input | VW | Second vector operand |
| old_dst | input | VW | Old destination, source for disabled lanes under merging |
| pred_idx | input | log2(NUM_MREG) | Mask register that predicates a predicated add |
| zero_off | input | 1 | 1 = zero disabled lanes, 0 = merge old destination |
| mask_wr_idx | input | log2(NUM_MREG) | Mask register that a compare writes |
| res_valid | output | 1 | Registered result valid |
| res_vec | output | VW | Registered result vector |
| res_mask | output | VW/8 | Registered compare mask |

## Verification
A corrupted mask register stays hidden until a predicated add reads it. The fault then shows in the very next result as lanes that merged when they should have added, or the reverse. For that reason the tests always pair each compare with a predicated add issued one cycle later, and use both merge and zero modes. A broken lane boundary in the adder shows in the same cycle's result as a carry leaking into a neighbouring lane. All-ones plus one per lane exposes this at every element size. A wrong lane-count limit shows as stray high mask bits on a 64-bit compare. It also shows as lanes wrongly enabled when a narrow mask is reused at byte width.

// File: rtl/vlalu_pkg.sv
package vlalu_pkg;
   typedef enum logic [1:0] {
      OP_ADD   = 2'b00,
      OP_CMPGT = 2'b01,
      OP_MADD  = 2'b10,
      OP_RSVD  = 2'b11
   } vl_op_e;

   typedef enum logic [1:0] {
      ES_8  = 2'b00,
      ES_16 = 2'b01,
      ES_32 = 2'b10,
      ES_64 = 2'b11
   } vl_es_e;
endpackage

// File: rtl/vlalu_seg_add.sv
// Byte-sliced adder whose carry chain is broken at every lane boundary.
module vlalu_seg_add #(
   parameter int VW = 512
) (
   input  logic [1:0]    esize,
   input  logic [VW-1:0] a,
   input  logic [VW-1:0] b,
   output logic [VW-1:0] sum
);
   localparam int NB = VW / 8;

   logic [NB-2:0] cy;

   for (genvar i = 0; i < NB; i++) begin : g_byte
      localparam int unsigned POS = i % 8;
      localparam logic [2:0] LOW = POS[2:0];
      logic first;
      logic cin;

      always_comb begin
         unique case (esize)
            2'b00:   first = 1'b1;
            2'b01:   first = (LOW[0] == 1'b0);
            2'b10:   first = (LOW[1:0] == 2'b00);
            default: first = (LOW == 3'b000);
         endcase
      end

      if (i == 0) begin : g_c0
         assign cin = 1'b0;
      end else begin : g_cn
         assign cin = first ? 1'b0 : cy[i-1];
      end

      if (i < NB - 1) begin : g_mid
         assign {cy[i], sum[8*i +: 8]} = {1'b0, a[8*i +: 8]} + {1'b0, b[8*i +: 8]} + {8'd0, cin};
      end else begin : g_top
         assign sum[8*i +: 8] = a[8*i +: 8] + b[8*i +: 8] + {7'd0, cin};
      end
   end
endmodule

// File: rtl/vlalu_lane_cmp.sv
// Signed greater-than per lane; one comparator array per element size.
module vlalu_lane_cmp #(
   parameter int VW = 512
) (
   input  logic [1:0]      esize,
   input  logic [VW-1:0]   a,
   input  logic [VW-1:0]   b,
   output logic [VW/8-1:0] gt
);
   localparam int NL = VW / 8;

   logic [NL-1:0] m_sz [4];

   for (genvar g = 0; g < 4; g++) begin : g_sz
      localparam int W = 8 << g;
      localparam int N = VW / W;
      for (genvar k = 0; k < NL; k++) begin : g_ln
         if (k < N) begin : g_on
            assign m_sz[g][k] = $signed(a[k*W +: W]) > $signed(b[k*W +: W]);
         end else begin : g_off
            assign m_sz[g][k] = 1'b0;
         end
      end
   end

   assign gt = m_sz[esize];
endmodule

// File: rtl/vlalu_mask_rf.sv
// Mask register bank; index 0 reads as all ones and ignores writes.
module vlalu_mask_rf #(
   parameter int NR = 8,
   parameter int MW = 64,
   localparam int IW = $clog2(NR)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we,
   input  logic [IW-1:0] wa,
   input  logic [MW-1:0] wd,
   input  logic [IW-1:0] ra,
   output logic [MW-1:0] rd
);
   logic [MW-1:0] regs [NR];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int r = 0; r < NR; r++) regs[r] <= '0;
      end else if (we && (wa != '0)) begin
         regs[wa] <= wd;
      end
   end

   assign rd = (ra == '0) ? '1 : regs[ra];
endmodule

// File: rtl/vec_lane_alu.sv
module vec_lane_alu
   import vlalu_pkg::*;
#(
   parameter int VW       = 512,
   parameter int NUM_MREG = 8,
   localparam int NL      = VW / 8,
   localparam int IW      = $clog2(NUM_MREG)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          in_valid,
   input  logic [1:0]    opcode,
   input  logic [1:0]    elem_size,
   input  logic [VW-1:0] src_a,
   input  logic [VW-1:0] src_b,
   input  logic [VW-1:0] old_dst,
   input  logic [IW-1:0] pred_idx,
   input  logic          zero_off,
   input  logic [IW-1:0] mask_wr_idx,
   output logic          res_valid,
   output logic [VW-1:0] res_vec,
   output logic [NL-1:0] res_mask
);
   if ((VW % 64) != 0 || VW < 64) begin : g_bad_vw
      $error("vec_lane_alu: VW must be a positive multiple of 64");
   end
   if (NUM_MREG < 2) begin : g_bad_nr
      $error("vec_lane_alu: NUM_MREG must be at least 2");
   end

   vl_op_e        opc;
   logic [VW-1:0] sum;
   logic [NL-1:0] gt;
   logic [NL-1:0] rng;
   logic [NL-1:0] mrd;
   logic [NL-1:0] pred;
   logic [NL-1:0] byte_en;
   logic [VW-1:0] madd_vec;
   logic [VW-1:0] nxt_vec;
   logic [NL-1:0] nxt_mask;
   logic          mwe;

   assign opc = vl_op_e'(opcode);

   vlalu_seg_add #(.VW(VW)) i_add (
      .esize(elem_size), .a(src_a), .b(src_b), .sum(sum)
   );

   vlalu_lane_cmp #(.VW(VW)) i_cmp (
      .esize(elem_size), .a(src_a), .b(src_b), .gt(gt)
   );

   // lanes that exist at the current element size
   always_comb begin
      rng = '0;
      for (int k = 0; k < NL; k++) begin
         if (k < (NL >> elem_size)) rng[k] = 1'b1;
      end
   end

   assign mwe = in_valid && (opc == OP_CMPGT);

   vlalu_mask_rf #(.NR(NUM_MREG), .MW(NL)) i_mrf (
      .clk(clk), .rst(rst), .we(mwe), .wa(mask_wr_idx),
      .wd(gt & rng), .ra(pred_idx), .rd(mrd)
   );

   assign pred = mrd & rng;

   // spread one predicate bit over the bytes of its lane
   for (genvar i = 0; i < NL; i++) begin : g_be
      always_comb begin
         unique case (elem_size)
            2'b00:   byte_en[i] = pred[i];
            2'b01:   byte_en[i] = pred[i/2];
            2'b10:   byte_en[i] = pred[i/4];
            default: byte_en[i] = pred[i/8];
         endcase
      end
      assign madd_vec[8*i +: 8] = byte_en[i] ? sum[8*i +: 8]
                                 : (zero_off ? 8'h00 : old_dst[8*i +: 8]);
   end

   always_comb begin
      nxt_vec  = '0;
      nxt_mask = '0;
      unique case (opc)
         OP_ADD:   nxt_vec  = sum;
         OP_CMPGT: nxt_mask = gt & rng;
         OP_MADD:  nxt_vec  = madd_vec;
         default:  ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         res_valid <= 1'b0;
         res_vec   <= '0;
         res_mask  <= '0;
      end else begin
         res_valid <= in_valid;
         if (in_valid) begin
            res_vec  <= nxt_vec;
            res_mask <= nxt_mask;
         end
      end
   end
endmodule

// File: rtl/vlalu_chk.sv
module vlalu_chk #(
   parameter int VW = 512,
   parameter int IW = 3,
   localparam int NL = VW / 8
) (
   input logic          clk,
   input logic          rst,
   input logic          in_valid,
   input logic [1:0]    opcode,
   input logic [1:0]    elem_size,
   input logic [VW-1:0] src_a,
   input logic [VW-1:0] src_b,
   input logic [IW-1:0] pred_idx,
   input logic          res_valid,
   input logic [VW-1:0] res_vec,
   input logic [NL-1:0] res_mask
);
   AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> res_valid); // R8
   AST_VALID_FALL: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!res_valid && $stable(res_vec) && $stable(res_mask))); // R8
   AST_WIDE_MASK_RANGE: assert property (@(posedge clk) disable iff (rst)
      (in_valid && opcode == 2'b01 && elem_size == 2'b11) |=> (res_mask[NL-1:NL/8] == '0)); // R3
   AST_MID_MASK_RANGE: assert property (@(posedge clk) disable iff (rst)
      (in_valid && opcode == 2'b01 && elem_size == 2'b10) |=> (res_mask[NL-1:NL/4] == '0)); // R3
   AST_NONCMP_MASK_ZERO: assert property (@(posedge clk) disable iff (rst)
      (in_valid && opcode != 2'b01) |=> (res_mask == '0)); // R10
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
      (in_valid && opcode == 2'b11) |=> (res_vec == '0)); // R10
   AST_ADD_IDENT: assert property (@(posedge clk) disable iff (rst)
      (in_valid && opcode == 2'b00 && src_b == '0) |=> (res_vec == $past(src_a))); // R2
   AST_IDX0_ALL_ON: assert property (@(posedge clk) disable iff (rst)
      (in_valid && opcode == 2'b10 && pred_idx == '0 && src_b == '0) |=> (res_vec == $past(src_a))); // R7
endmodule

bind vec_lane_alu vlalu_chk #(.VW(VW), .IW(IW)) i_vlalu_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
   .elem_size(elem_size), .src_a(src_a), .src_b(src_b), .pred_idx(pred_idx),
   .res_valid(res_valid), .res_vec(res_vec), .res_mask(res_mask)
);

// File: tb/test_vec_lane_alu.sv
`timescale 1ns/1ps
module test_vec_lane_alu;
   localparam int VW = 512;
   localparam int NL = VW / 8;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst;
   logic          in_valid;
   logic [1:0]    opcode;
   logic [1:0]    elem_size;
   logic [VW-1:0] src_a, src_b, old_dst;
   logic [IW-1:0] pred_idx, mask_wr_idx;
   logic          zero_off;
   logic          res_valid;
   logic [VW-1:0] res_vec;
   logic [NL-1:0] res_mask;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   vec_lane_alu #(.VW(VW), .NUM_MREG(8)) i_vec_lane_alu (
      .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
      .elem_size(elem_size), .src_a(src_a), .src_b(src_b), .old_dst(old_dst),
      .pred_idx(pred_idx), .zero_off(zero_off), .mask_wr_idx(mask_wr_idx),
      .res_valid(res_valid), .res_vec(res_vec), .res_mask(res_mask)
   );

   function automatic logic [VW-1:0] pat(int seed);
      logic [VW-1:0] r = '0;
      for (int k = 0; k < VW/32; k++)
         r[32*k +: 32] = (seed * 32'h9E3779B1) ^ (k * 32'h85EBCA6B) + k * 32'h01234567;
      return r;
   endfunction

   function automatic logic [63:0] wmask(int e);
      int w = 8 << e;
      return (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
   endfunction

   // lane-wise model: predicated add with merge or zero
   function automatic logic [VW-1:0] m_add(logic [VW-1:0] a, logic [VW-1:0] b, int e,
                                           logic [NL-1:0] pr, logic zr, logic [VW-1:0] old);
      logic [VW-1:0] r = '0;
      int w = 8 << e;
      logic [63:0] la, lb, lo, lr;
      for (int i = 0; i < (VW / w); i++) begin
         la = 64'(a >> (i*w)) & wmask(e);
         lb = 64'(b >> (i*w)) & wmask(e);
         lo = 64'(old >> (i*w)) & wmask(e);
         lr = pr[i] ? ((la + lb) & wmask(e)) : (zr ? 64'd0 : lo);
         r = r | (VW'(lr) << (i*w));
      end
      return r;
   endfunction

   function automatic logic [NL-1:0] m_gt(logic [VW-1:0] a, logic [VW-1:0] b, int e);
      logic [NL-1:0] r = '0;
      int w = 8 << e;
      logic [63:0] la, lb;
      for (int i = 0; i < (VW / w); i++) begin
         la = (64'(a >> (i*w)) & wmask(e)) << (64 - w);
         lb = (64'(b >> (i*w)) & wmask(e)) << (64 - w);
         r[i] = $signed(la) > $signed(lb);
      end
      return r;
   endfunction

   task automatic chk_vec(string req, logic [VW-1:0] act, logic [VW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s vec actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic chk_msk(string req, logic [NL-1:0] act, logic [NL-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s mask actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic chk_bit(string req, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s bit actual %b expected %b", req, act, exp);
      end
   endtask

   // drive one instruction, sample the registered result after the edge
   task automatic issue(logic [1:0] op, logic [1:0] es, logic [VW-1:0] a, logic [VW-1:0] b,
                        logic [VW-1:0] old, logic [IW-1:0] pi, logic zr, logic [IW-1:0] wi);
      @(negedge clk);
      in_valid = 1'b1; opcode = op; elem_size = es; src_a = a; src_b = b;
      old_dst = old; pred_idx = pi; zero_off = zr; mask_wr_idx = wi;
      @(posedge clk); #1;
      in_valid = 1'b0;
   endtask

   task automatic t_reset();
      rst = 1'b1; in_valid = 1'b0; opcode = 2'b00; elem_size = 2'b00;
      src_a = '0; src_b = '0; old_dst = '0; pred_idx = '0; zero_off = 1'b0; mask_wr_idx = '0;
      repeat (3) @(posedge clk);
      #1;
      chk_bit("R9 valid after reset", res_valid, 1'b0);
      chk_vec("R9 vec after reset", res_vec, '0);
      chk_msk("R9 mask after reset", res_mask, '0);
      @(negedge clk); rst = 1'b0;
      issue(2'b10, 2'b00, pat(1), pat(2), pat(7), 3'd5, 1'b0, 3'd0);
      chk_vec("R9 cleared mask merges", res_vec, pat(7));
      issue(2'b10, 2'b10, pat(1), pat(2), pat(7), 3'd3, 1'b1, 3'd0);
      chk_vec("R9 cleared mask zeroes", res_vec, '0);
   endtask

   task automatic t_add();
      for (int e = 0; e < 4; e++) begin
         logic [VW-1:0] ones = '0;
         for (int i = 0; i < (VW >> (3 + e)); i++) ones = ones | (VW'(1) << (i * (8 << e)));
         issue(2'b00, 2'(e), '1, ones, pat(9), 3'd0, 1'b0, 3'd0);
         chk_vec($sformatf("R2 lane wrap no carry es=%0d", e), res_vec, '0);
         chk_msk("R10 add mask zero", res_mask, '0);
         issue(2'b00, 2'(e), pat(10 + e), pat(20 + e), pat(9), 3'd0, 1'b0, 3'd0);
         chk_vec($sformatf("R1 add pattern es=%0d", e), res_vec,
                 m_add(pat(10 + e), pat(20 + e), e, '1, 1'b0, '0));
      end
   endtask

   task automatic t_cmp();
      for (int e = 0; e < 4; e++) begin
         issue(2'b01, 2'(e), pat(30 + e), pat(40 + e), pat(5), 3'd0, 1'b0, 3'd3);
         chk_msk($sformatf("R3 compare es=%0d", e), res_mask, m_gt(pat(30 + e), pat(40 + e), e));
         chk_vec("R10 compare vec zero", res_vec, '0);
      end
      // reg 3 holds an 8-lane mask; reused at byte width, lanes 8..63 stay off
      issue(2'b10, 2'b00, pat(50), pat(51), pat(52), 3'd3, 1'b0, 3'd0);
      chk_vec("R4 narrow mask reused wide", res_vec,
              m_add(pat(50), pat(51), 0, m_gt(pat(33), pat(43), 3), 1'b0, pat(52)));
   endtask

   task automatic t_madd();
      logic [NL-1:0] m;
      m = m_gt(pat(60), pat(61), 2);
      issue(2'b01, 2'b10, pat(60), pat(61), '0, 3'd0, 1'b0, 3'd2);
      issue(2'b10, 2'b10, pat(62), pat(63), pat(64), 3'd2, 1'b0, 3'd0);
      chk_vec("R5 merge next cycle", res_vec, m_add(pat(62), pat(63), 2, m, 1'b0, pat(64)));
      issue(2'b10, 2'b10, pat(62), pat(63), pat(64), 3'd2, 1'b1, 3'd0);
      chk_vec("R6 zeroing", res_vec, m_add(pat(62), pat(63), 2, m, 1'b1, pat(64)));
      issue(2'b10, 2'b10, pat(65), pat(66), pat(65), 3'd2, 1'b0, 3'd0);
      chk_vec("R5 merge source is A", res_vec, m_add(pat(65), pat(66), 2, m, 1'b0, pat(65)));
   endtask

   task automatic t_idx0();
      issue(2'b01, 2'b01, '0, '1, '0, 3'd0, 1'b0, 3'd0);
      chk_msk("R3 all lanes greater", res_mask, {(NL/2){1'b1}} & m_gt('0, '1, 1));
      issue(2'b10, 2'b01, pat(70), pat(71), pat(72), 3'd0, 1'b1, 3'd0);
      chk_vec("R7 index 0 all lanes on", res_vec, m_add(pat(70), pat(71), 1, '1, 1'b0, '0));
      issue(2'b01, 2'b00, pat(73), pat(74), '0, 3'd0, 1'b0, 3'd6);
      issue(2'b01, 2'b00, '0, '0, '0, 3'd0, 1'b0, 3'd0);
      issue(2'b10, 2'b00, pat(75), pat(76), pat(77), 3'd6, 1'b0, 3'd0);
      chk_vec("R4 write to 0 leaves reg 6", res_vec,
              m_add(pat(75), pat(76), 0, m_gt(pat(73), pat(74), 0), 1'b0, pat(77)));
   endtask

   task automatic t_idle();
      logic [VW-1:0] held;
      issue(2'b00, 2'b11, pat(80), pat(81), '0, 3'd0, 1'b0, 3'd0);
      chk_bit("R8 valid one cycle later", res_valid, 1'b1);
      held = res_vec;
      @(negedge clk); src_a = pat(90); opcode = 2'b11;
      @(posedge clk); #1;
      chk_bit("R8 valid low when idle", res_valid, 1'b0);
      chk_vec("R8 result held when idle", res_vec, held);
   endtask

   task automatic t_rsvd();
      issue(2'b11, 2'b00, pat(85), pat(86), pat(87), 3'd0, 1'b0, 3'd4);
      chk_vec("R10 reserved vec zero", res_vec, '0);
      chk_msk("R10 reserved mask zero", res_mask, '0);
   endtask

   initial begin
      t_reset();
      t_add();
      t_cmp();
      t_madd();
      t_idx0();
      t_idle();
      t_rsvd();
      repeat (2) @(posedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule